// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked serial link, least significant bit first. A host writes a byte into a holding register. The block moves that byte into an 8-bit shift register and frees the holding register at once, so the host can queue the next byte while the current one is still going out. Two flags report progress. The "empty" flag is set when the holding register can take a new byte. The "end" flag is set when the line has gone quiet with nothing queued. Each flag, gated by its own enable bit, drives a level interrupt request.

The serial clock has two sources. In internal mode the block makes the clock itself by dividing the system clock by twice a programmable half-period. It drives that clock out only while a frame is in progress, and the clock rests high otherwise. In external mode an incoming clock is passed through a two-flop synchronizer, and the block shifts on the falling edges it detects. Data always changes on a falling serial-clock edge, so a receiver samples it on the rising edge.

The holding register is checked at the falling edge that puts the MSB on the line. If a byte is waiting there, the next frame follows with no idle time. If none is waiting, the end flag is set and the clock stops after the MSB's rising edge.

The FSM has three states. ST_IDLE holds the clock high with nothing shifting. ST_LOW covers the serial-clock low half of a bit. ST_HIGH covers the high half of a bit. The transitions are:
- Start (ST_IDLE→ST_LOW): a falling event arrives while a byte is queued. The byte is loaded and bit 0 is driven.
- Rise (ST_LOW→ST_HIGH): a rising event arrives.
- Finish (ST_LOW→ST_IDLE): a rising event arrives on the MSB with no follow-on frame.
- Next-bit (ST_HIGH→ST_LOW): a falling event arrives. On the MSB this is also the point of the queue check.
- Chain (ST_HIGH→ST_LOW): a falling event arrives after the MSB of a chained frame. Bit 0 of the new byte is driven.

Top module: `sst_tx`

## Requirements
- R1: After reset, the empty flag is 1, the end flag is 1, txd is 1 and sclk_out is 1.
- R2: A host write clears the empty flag in the following cycle. Loading the held byte into the shift register sets the empty flag. If a write and a load happen in the same cycle, the write wins: the flag stays 0 and the newly written byte is kept for the next frame.
- R3: Each frame sends bits 0 through 7 in that order. In internal mode each frame has exactly 8 low clock pulses. Each clock half lasts div_half system cycles, and a value of 0 is treated as 1. txd changes only on a falling clock edge.
- R4: If a byte is written before the MSB of the current frame goes out, the next frame follows with no gap. The clock period stays constant across the boundary, and the end flag stays 0.
- R5: If the holding register is empty when the MSB goes out, the end flag is set at that falling edge, half a bit before the final rising edge. After that rising edge, sclk_out stays high and txd holds the MSB.
- R6: Loading a byte clears the end flag. A pulse on tend_clr also clears it.
- R7: irq_empty equals the empty flag ANDed with empty_irq_en. irq_end equals the end flag ANDed with end_irq_en.
- R8: When ext_clk_sel is 1, sclk_out stays at 1. A queued byte waits for a falling edge on sclk_in, and the block then shifts one bit on each synchronized falling edge.
- R9: In internal mode, a write to an idle transmitter starts the frame on the second cycle after the write. At that point the empty flag is already set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_sel | input | 1 | 1 selects the external serial clock, 0 selects the internal divider |
| div_half | input | 8 | Internal clock half-period in system cycles (0 acts as 1) |
| empty_irq_en | input | 1 | Enable for the empty interrupt |
| end_irq_en | input | 1 | Enable for the end interrupt |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| tend_clr | input | 1 | Strobe that clears the end flag |
| sclk_in | input | 1 | External serial clock |
| tdr_empty | output | 1 | Holding register empty flag |
| tx_end | output | 1 | Transmission end flag |
| irq_empty | output | 1 | Empty interrupt request (level) |
| irq_end | output | 1 | End interrupt request (level) |
| sclk_out | output | 1 | Generated serial clock, idles high |
| txd | output | 1 | Serial data |

## Verification
The bench targets the MSB-time queue check from both sides. A byte queued just after a load must chain with an unchanged clock spacing. A design that checked late would insert an idle gap or set the end flag early. A design that checked too early would drop the second byte.

A write that lands in the same cycle as a load must survive. If the load won, the second byte would vanish and only one frame would go out.

The bench also checks three timing points:
- the end flag must rise exactly one half-period before the last clock rise;
- a zero divider must act as a divide-by-two;
- the external mode must stay still until sclk_in falls. A design that ignored the clock source would start on its own divider.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } tx_state_t;
endpackage

// File: rtl/sst_edge_src.sv
module sst_edge_src #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [DIV_W-1:0] div_half,
    input  logic             run,
    input  logic             phase_low,
    input  logic             start_req,
    input  logic             sclk_in,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int LAST_STAGE = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_r;
    logic                   sync_d;
    logic [DIV_W-1:0]       cnt_q;
    logic [DIV_W-1:0]       limit;
    logic                   tick;
    logic                   ext_rise, ext_fall;
    logic                   int_rise, int_fall;

    // two-flop (or longer) synchronizer on the incoming clock, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_r <= '1;
            sync_d <= 1'b1;
        end else begin
            sync_r <= {sync_r[SYNC_STAGES-2:0], sclk_in};
            sync_d <= sync_r[LAST_STAGE];
        end
    end

    assign ext_rise = sync_r[LAST_STAGE] & ~sync_d;
    assign ext_fall = ~sync_r[LAST_STAGE] & sync_d;

    // half-period divider, held at zero while idle
    assign limit = (div_half == '0) ? '0 : div_half - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q >= limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick     = run && (cnt_q >= limit);
    assign int_rise = tick & phase_low;
    assign int_fall = (tick & ~phase_low) | (~run & start_req);

    assign rise_evt = ext_mode ? ext_rise : int_rise;
    assign fall_evt = ext_mode ? ext_fall : int_fall;

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_evt && fall_evt));

    a_r3_no_rise_in_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && run && !phase_low) |-> !rise_evt);
endmodule

// File: rtl/sst_flags.sv
module sst_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              end_set,
    input  logic              tend_clr,
    input  logic              empty_irq_en,
    input  logic              end_irq_en,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q,
    output logic              tend_q,
    output logic              irq_empty,
    output logic              irq_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    // write beats load: a byte written in the load cycle stays queued
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (wr_en) begin
            empty_q <= 1'b0;
        end else if (load) begin
            empty_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tend_q <= 1'b1;
        end else if (end_set) begin
            tend_q <= 1'b1;
        end else if (load || tend_clr) begin
            tend_q <= 1'b0;
        end
    end

    assign irq_empty = empty_q & empty_irq_en;
    assign irq_end   = tend_q & end_irq_en;

    a_r2_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> empty_q);

    a_r2_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !empty_q);

    a_r6_load_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !end_set) |=> !tend_q);

    a_r5_end_and_load_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && end_set));
endmodule

// File: rtl/sst_tx_fsm.sv
module sst_tx_fsm
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              empty,
    input  logic [DATA_W-1:0] hold_q,
    output logic              load,
    output logic              end_set,
    output logic              run,
    output logic              phase_low,
    output logic              txd,
    output logic              sclk_out
);
    localparam int                CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  MSB_IDX = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  PRE_MSB = CNT_W'(DATA_W - 2);

    tx_state_t         state_q, state_nx;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CNT_W-1:0]  bit_nx;
    logic              chain_q;
    logic              txd_q;
    logic              sclk_q;

    assign bit_nx = bit_q + 1'b1;

    // next state and strobes
    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        end_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_evt && !empty) begin
                    load     = 1'b1;
                    state_nx = ST_LOW;
                end
            end
            ST_LOW: begin
                if (rise_evt) begin
                    state_nx = (bit_q == MSB_IDX && !chain_q) ? ST_IDLE : ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (fall_evt) begin
                    state_nx = ST_LOW;
                    if (bit_q == PRE_MSB) begin
                        if (!empty) begin
                            load = 1'b1;
                        end else begin
                            end_set = 1'b1;
                        end
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // datapath and line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            chain_q <= 1'b0;
            txd_q   <= 1'b1;
            sclk_q  <= 1'b1;
        end else begin
            sclk_q <= ext_mode || (state_nx != ST_LOW);
            if (state_q == ST_IDLE && load) begin
                shreg_q <= hold_q;
                txd_q   <= hold_q[0];
                bit_q   <= '0;
                chain_q <= 1'b0;
            end else if (state_q == ST_HIGH && fall_evt) begin
                if (bit_q == MSB_IDX) begin
                    txd_q   <= shreg_q[0];
                    bit_q   <= '0;
                    chain_q <= 1'b0;
                end else begin
                    txd_q <= shreg_q[bit_nx];
                    bit_q <= bit_nx;
                    if (load) begin
                        shreg_q <= hold_q;
                        chain_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign run       = (state_q != ST_IDLE);
    assign phase_low = (state_q == ST_LOW);
    assign txd       = txd_q;
    assign sclk_out  = sclk_q;

    a_r3_txd_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(txd_q));

    a_r5_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> sclk_q);

    a_r4_chain_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && chain_q) |=> (state_q != ST_IDLE));

    a_r8_ext_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_mode) && ext_mode) |-> sclk_q);
endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_sel,
    input  logic [DIV_W-1:0] div_half,
    input  logic             empty_irq_en,
    input  logic             end_irq_en,
    input  logic             wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic             tend_clr,
    input  logic             sclk_in,
    output logic             tdr_empty,
    output logic             tx_end,
    output logic             irq_empty,
    output logic             irq_end,
    output logic             sclk_out,
    output logic             txd
);
    logic              load_w, end_set_w, run_w, low_w;
    logic              rise_w, fall_w;
    logic              empty_w, tend_w;
    logic [DATA_W-1:0] hold_w;

    sst_edge_src #(
        .DIV_W       (DIV_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_clk_sel),
        .div_half  (div_half),
        .run       (run_w),
        .phase_low (low_w),
        .start_req (~empty_w),
        .sclk_in   (sclk_in),
        .rise_evt  (rise_w),
        .fall_evt  (fall_w)
    );

    sst_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .load         (load_w),
        .end_set      (end_set_w),
        .tend_clr     (tend_clr),
        .empty_irq_en (empty_irq_en),
        .end_irq_en   (end_irq_en),
        .hold_q       (hold_w),
        .empty_q      (empty_w),
        .tend_q       (tend_w),
        .irq_empty    (irq_empty),
        .irq_end      (irq_end)
    );

    sst_tx_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_clk_sel),
        .rise_evt  (rise_w),
        .fall_evt  (fall_w),
        .empty     (empty_w),
        .hold_q    (hold_w),
        .load      (load_w),
        .end_set   (end_set_w),
        .run       (run_w),
        .phase_low (low_w),
        .txd       (txd),
        .sclk_out  (sclk_out)
    );

    assign tdr_empty = empty_w;
    assign tx_end    = tend_w;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && tend_w) |-> sclk_out);
endmodule

// File: tb/sst_tx_bench.sv
`timescale 1ns/1ps
module sst_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_sel = 1'b0;
    logic [7:0] div_half = 8'd3;
    logic       empty_irq_en = 1'b1;
    logic       end_irq_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tend_clr = 1'b0;
    logic       sclk_in = 1'b1;
    logic       tdr_empty, tx_end, irq_empty, irq_end, sclk_out, txd;

    always #2 clk = ~clk;

    sst_tx u_sst_tx (
        .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .div_half(div_half),
        .empty_irq_en(empty_irq_en), .end_irq_en(end_irq_en), .wr_en(wr_en),
        .wr_data(wr_data), .tend_clr(tend_clr), .sclk_in(sclk_in),
        .tdr_empty(tdr_empty), .tx_end(tx_end), .irq_empty(irq_empty),
        .irq_end(irq_end), .sclk_out(sclk_out), .txd(txd)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // line monitor: records bits at receiver-side rising clock edges
    logic     rx_bits [0:255];
    int       rise_time [0:255];
    logic     tend_at_rise [0:255];
    int       rise_cnt = 0;
    int       bad_edge = 0;
    int       tend_cyc = 0;
    logic     prev_src = 1'b1;
    logic     prev_txd = 1'b1;
    logic     prev_tend = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        logic src;
        src = ext_clk_sel ? sclk_in : sclk_out;
        if (rst_n) begin
            if (src && !prev_src && rise_cnt < 256) begin
                rx_bits[rise_cnt]      = txd;
                rise_time[rise_cnt]    = cyc;
                tend_at_rise[rise_cnt] = tx_end;
                rise_cnt = rise_cnt + 1;
            end
            if (txd != prev_txd && src) bad_edge = bad_edge + 1;
            if (tx_end && !prev_tend) tend_cyc = cyc;
        end
        prev_src  = src;
        prev_txd  = txd;
        prev_tend = tx_end;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] got_byte(input int base, input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = rx_bits[base + 8*k + i];
        return b;
    endfunction

    task automatic write_byte(input logic [7:0] d);
        step();
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic wait_rises(input int target, input string tag);
        int n = 0;
        while (rise_cnt < target && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(rise_cnt >= target, tag, rise_cnt, target);
    endtask

    task automatic check_spacing(input int base, input int n, input int half, input string tag);
        int mis = 0;
        int first = 0;
        for (int i = 0; i < n - 1; i++) begin
            if (rise_time[base+i+1] - rise_time[base+i] != 2*half) begin
                if (mis == 0) first = rise_time[base+i+1] - rise_time[base+i];
                mis++;
            end
        end
        chk(mis == 0, tag, (mis == 0) ? 2*half : first, 2*half);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tdr_empty == 1'b1, "R1 empty after reset", tdr_empty, 1);
        chk(tx_end == 1'b1, "R1 end after reset", tx_end, 1);
        chk(txd == 1'b1, "R1 txd after reset", txd, 1);
        chk(sclk_out == 1'b1, "R1 sclk after reset", sclk_out, 1);
        chk(irq_empty == 1'b1 && irq_end == 1'b1, "R7 irqs enabled", {irq_empty, irq_end}, 3);
        step();
        empty_irq_en = 1'b0;
        end_irq_en   = 1'b0;
        @(negedge clk);
        chk(irq_empty == 1'b0 && irq_end == 1'b0, "R7 irqs masked", {irq_empty, irq_end}, 0);
        step();
        empty_irq_en = 1'b1;
        end_irq_en   = 1'b1;
    endtask

    task automatic t_single();
        int base;
        int rc;
        base = rise_cnt;
        div_half = 8'd3;
        write_byte(8'h5A);
        @(negedge clk);
        chk(tdr_empty == 1'b0, "R2 write clears empty", tdr_empty, 0);
        chk(irq_empty == 1'b0, "R7 irq_empty low", irq_empty, 0);
        @(negedge clk);
        chk(tdr_empty == 1'b1, "R9 empty set at start", tdr_empty, 1);
        chk(sclk_out == 1'b0, "R9 clock low at start", sclk_out, 0);
        chk(tx_end == 1'b0, "R6 load clears end", tx_end, 0);
        chk(irq_empty == 1'b1, "R7 irq_empty follows", irq_empty, 1);
        wait_rises(base + 8, "R3 single frame rises");
        repeat (10) @(negedge clk);
        chk(got_byte(base, 0) == 8'h5A, "R3 LSB-first byte", got_byte(base, 0), 8'h5A);
        chk(rise_cnt - base == 8, "R3 eight pulses", rise_cnt - base, 8);
        check_spacing(base, 8, 3, "R3 period 2*div");
        chk(tx_end == 1'b1 && irq_end == 1'b1, "R5 end flag and irq", {tx_end, irq_end}, 3);
        chk(rise_time[base+7] - tend_cyc == 3, "R5 end set at MSB fall", rise_time[base+7] - tend_cyc, 3);
        chk(txd == 1'b0, "R5 txd holds MSB", txd, 0);
        rc = rise_cnt;
        repeat (30) @(negedge clk);
        chk(rise_cnt == rc && sclk_out == 1'b1, "R5 clock parked high", rise_cnt - rc, 0);
    endtask

    task automatic t_clear_end();
        step();
        tend_clr = 1'b1;
        step();
        tend_clr = 1'b0;
        @(negedge clk);
        chk(tx_end == 1'b0, "R6 strobe clears end", tx_end, 0);
        chk(irq_end == 1'b0, "R7 irq_end drops", irq_end, 0);
    endtask

    task automatic t_back_to_back();
        int base;
        base = rise_cnt;
        div_half = 8'd2;
        write_byte(8'hC3);
        while (tdr_empty != 1'b1) @(negedge clk);
        write_byte(8'h96);
        wait_rises(base + 16, "R4 two frames rises");
        repeat (10) @(negedge clk);
        chk(got_byte(base, 0) == 8'hC3, "R4 first byte", got_byte(base, 0), 8'hC3);
        chk(got_byte(base, 1) == 8'h96, "R4 second byte", got_byte(base, 1), 8'h96);
        check_spacing(base, 16, 2, "R4 no gap between frames");
        chk(tend_at_rise[base+7] == 1'b0, "R4 end stays low on chain", tend_at_rise[base+7], 0);
        chk(tx_end == 1'b1, "R5 end after last frame", tx_end, 1);
    endtask

    task automatic t_write_wins();
        int base;
        base = rise_cnt;
        div_half = 8'd1;
        step();
        wr_en = 1'b1;
        wr_data = 8'h3C;
        step();
        wr_data = 8'hE1;
        step();
        wr_en = 1'b0;
        @(negedge clk);
        chk(tdr_empty == 1'b0, "R2 write beats load", tdr_empty, 0);
        wait_rises(base + 16, "R2 queued byte sent");
        repeat (8) @(negedge clk);
        chk(got_byte(base, 0) == 8'h3C, "R2 first byte", got_byte(base, 0), 8'h3C);
        chk(got_byte(base, 1) == 8'hE1, "R2 kept byte", got_byte(base, 1), 8'hE1);
    endtask

    task automatic t_div_zero();
        int base;
        base = rise_cnt;
        div_half = 8'd0;
        write_byte(8'h81);
        wait_rises(base + 8, "R3 div0 rises");
        repeat (8) @(negedge clk);
        chk(got_byte(base, 0) == 8'h81, "R3 div0 byte", got_byte(base, 0), 8'h81);
        check_spacing(base, 8, 1, "R3 div0 acts as 1");
    endtask

    task automatic t_external();
        int  base;
        logic hold_txd;
        step();
        ext_clk_sel = 1'b1;
        div_half = 8'd1;
        repeat (4) step();
        base = rise_cnt;
        hold_txd = txd;
        write_byte(8'hB1);
        repeat (12) @(negedge clk);
        chk(tdr_empty == 1'b0, "R8 waits for external edge", tdr_empty, 0);
        chk(txd == hold_txd, "R8 line idle before edge", txd, hold_txd);
        for (int p = 0; p < 8; p++) begin
            step();
            sclk_in = 1'b0;
            repeat (6) step();
            if (p == 3) chk(sclk_out == 1'b1, "R8 sclk_out parked", sclk_out, 1);
            sclk_in = 1'b1;
            repeat (6) step();
        end
        repeat (8) @(negedge clk);
        chk(rise_cnt - base == 8, "R8 external pulses", rise_cnt - base, 8);
        chk(got_byte(base, 0) == 8'hB1, "R8 external byte", got_byte(base, 0), 8'hB1);
        chk(tx_end == 1'b1 && tdr_empty == 1'b1, "R8 end after external frame", {tx_end, tdr_empty}, 3);
        chk(txd == 1'b1, "R5 txd holds MSB external", txd, 1);
        step();
        ext_clk_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_clear_end();
        t_back_to_back();
        t_write_wins();
        t_div_zero();
        t_external();
        chk(bad_edge == 0, "R3 txd only moves with clock low", bad_edge, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule